// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A single-port, clocked memory whose command interface never needs an idle cycle between a read and a write. On every rising edge the block decodes a chip select, a clock-enable, an advance/load control, a write enable and four byte-write strobes. From these it starts a read or a write at an external address, continues a burst at an internally stepped address, deselects, or stalls. Write data follows its address by two enabled edges. The write address and the byte strobes therefore travel through a two-stage pipeline, and the data path stays busy every cycle.

Reads are flow-through. The word at the latched address appears on `dout` in the cycle after the command edge. `dout_oe` tells an external pad ring when to drive the shared bus. The word is 36 bits in four 9-bit lanes, and the array depth is a parameter, kept small by default.

Top module: `zbt_sram`

## Requirements
- R1: While reset is asserted and after it is released, the block is deselected and `dout_oe` stays 0 whatever `oe_n` is. An advance (`adv`=1) issued before any load starts nothing.
- R2: An edge with `cke_n`=1 is ignored. No command is taken and the pipelines do not move. A read in its output cycle keeps driving the same word. Such an edge is not counted toward the write-data delay, and `din` is not sampled on it.
- R3: With `cke_n`=0, `adv`=0 and `cs_n`=1, the edge deselects the block. `dout_oe` is 0 from that edge on.
- R4: With `cke_n`=0, `adv`=0, `cs_n`=0 and `we_n`=1, the edge latches `addr` as a read. During the following cycle `dout` carries that word and `dout_oe`=1 when `oe_n`=0.
- R5: With `cke_n`=0, `adv`=0, `cs_n`=0 and `we_n`=0, the edge latches `addr` as a write. The data for that write is sampled from `din` on the second following edge that has `cke_n`=0.
- R6: For a write, `bw_n[i]`=0 enables lane i, which is bits `9*i+8 : 9*i`. Disabled lanes keep their stored value. The strobes are taken on the same edge as the address.
- R7: With `cke_n`=0 and `adv`=1 after a load, the edge continues the burst in the direction of the last load, and `cs_n` and `we_n` are ignored. After a deselect, `adv`=1 stays deselected.
- R8: With `order`=0 the burst is linear. The k-th access after a load at address A uses A with its two low bits replaced by (A[1:0]+k) mod 4.
- R9: With `order`=1 the burst is interleaved. The two low bits are A[1:0] XOR (k mod 4).
- R10: `dout_oe` is 1 only when `oe_n`=0 and a read is in its output cycle. When `oe_n`=1 the bus is released.
- R11: A read may follow a write with no idle edge, and a write may follow a read the same way. If a read's output cycle is the cycle in which `din` carries a pending write to the same address, `dout` returns the enabled lanes from `din` and the other lanes from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; 1 inserts a wait state |
| cs_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load address |
| we_n | input | 1 | Write enable on load, active low |
| bw_n | input | 4 | Byte-lane write strobes, active low |
| order | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | External word address |
| din | input | 36 | Write data, two enabled edges after its address |
| dout | output | 36 | Read data (0 while not driving) |
| dout_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench stalls the clock in the middle of a write burst and presents junk on `din` during the stall. A design that counted the stalled edge would store the junk. It runs both burst orders from a start offset that is not zero, including the wrap past the fourth access, so a design with swapped or misstepped ordering reads back the wrong word. A byte-masked write checks that a design which writes all lanes corrupts the lanes it should have kept. A read issued right behind a write to the same address checks forwarding; without it, a stale array word would appear. Advance after deselect and after reset must stay silent, and a design that resumed an old burst would drive the bus.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs_n,
  input  logic             adv,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             order,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic             act, last_wr;
  logic [AW-1:0]    base;
  logic [1:0]       cnt;
  logic             rd_v;
  logic [AW-1:0]    rd_a;
  logic             w1_v, w2_v;
  logic [AW-1:0]    w1_a, w2_a;
  logic [LANES-1:0] w1_be, w2_be;

  wire en    = !cke_n;
  wire load  = en && !adv && !cs_n;
  wire desel = en && !adv && cs_n;
  wire burst = en && adv && act;
  wire go    = load || burst;

  wire [1:0] nxt_cnt = cnt + 2'd1;
  wire [1:0] nxt_lo  = order ? (base[1:0] ^ nxt_cnt) : (base[1:0] + nxt_cnt);
  wire [AW-1:0] cur_a = load ? addr : {base[AW-1:2], nxt_lo};
  wire is_wr = load ? !we_n : last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      last_wr <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd_v    <= 1'b0;
      rd_a    <= '0;
      w1_v    <= 1'b0;
      w1_a    <= '0;
      w1_be   <= '0;
      w2_v    <= 1'b0;
      w2_a    <= '0;
      w2_be   <= '0;
    end else if (en) begin
      if (load) begin
        base    <= addr;
        cnt     <= '0;
        act     <= 1'b1;
        last_wr <= !we_n;
      end else if (burst) begin
        cnt <= nxt_cnt;
      end else if (desel) begin
        act <= 1'b0;
      end
      rd_v  <= go && !is_wr;
      if (go) rd_a <= cur_a;
      w1_v  <= go && is_wr;
      w1_a  <= cur_a;
      w1_be <= ~bw_n;
      w2_v  <= w1_v;
      w2_a  <= w1_a;
      w2_be <= w1_be;
    end
  end

  always_ff @(posedge clk) begin
    if (en && w2_v)
      for (int i = 0; i < LANES; i++)
        if (w2_be[i]) mem[w2_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  logic [DW-1:0] arr, rdata;
  assign arr = mem[rd_a];
  wire hit = w2_v && (w2_a == rd_a);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[g*LANE_W +: LANE_W] = (hit && w2_be[g]) ? din[g*LANE_W +: LANE_W]
                                                         : arr[g*LANE_W +: LANE_W];
  end

  assign dout_oe = rd_v && !oe_n;
  assign dout    = dout_oe ? rdata : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic cke_n,
  input logic cs_n,
  input logic adv,
  input logic we_n,
  input logic oe_n,
  input logic dout_oe
);

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !dout_oe);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !oe_n) |=> (oe_n || (dout_oe == $past(dout_oe))));

  a_r3_deselect_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && cs_n && !adv) |=> !dout_oe);

  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !cs_n && !adv && we_n) |=> (oe_n || dout_oe));

  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !cs_n && !adv && !we_n) |=> !dout_oe);

  a_r10_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);

endmodule

bind zbt_sram zbt_sram_chk u_chk (.*);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, cke_n, cs_n, adv, we_n, order, oe_n, dout_oe;
  logic [3:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;

  zbt_sram #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .order(order), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] n, logic [3:0] b);
    logic [DW-1:0] r = o;
    for (int i = 0; i < 4; i++) if (!b[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  localparam logic [DW-1:0] DA = 36'h0A1B2C3D4, DB = 36'h955443322, DC = 36'h3CC0FFEE1,
                            DD = 36'h7D00DBEEF, E9 = 36'h123456789, E8 = 36'h876543210,
                            E11 = 36'hABCDEF012, E10 = 36'h0F0F0F0F0, NW = 36'hFEDCBA987,
                            GB = 36'hFFFFFFFFF, Z = 36'h0;

  typedef struct packed {
    logic cke_n, cs_n, adv, we_n;
    logic [3:0] bw_n;
    logic ord, oe_n;
    logic [5:0] a;
    logic [35:0] d;
    logic eo;
    logic [35:0] ed;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t V [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b0,6'd6,Z,  1'b0,Z},   // R5 write load @6
    '{1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,1'b0,6'd0,Z,  1'b0,Z},   // R7 burst write ->7, cs_n/we_n ignored
    '{1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,1'b0,6'd0,DA, 1'b0,Z},   // R8 ->4, data for 6
    '{1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,6'd0,DB, 1'b0,Z},   // R8 ->5, data for 7
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,DC, 1'b0,Z},   // R3 deselect, data for 4
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,DD, 1'b0,Z},   // R5 data for 5
    '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'd6,Z,  1'b1,DA},  // R4 read 6
    '{1'b0,1'b0,1'b1,1'b0,4'hF,1'b0,1'b0,6'd0,Z,  1'b1,DB},  // R7 R8 burst read 7
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b1,DC},  // R8 ->4
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b1,DD},  // R8 ->5
    '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1,6'd5,Z,  1'b0,Z},   // R10 read 5, oe_n high
    '{1'b1,1'b0,1'b0,1'b0,4'h0,1'b0,1'b0,6'd6,GB, 1'b1,DD},  // R2 stall holds read
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b0,Z},   // R3 deselect
    '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b1,1'b0,6'd9,Z,  1'b0,Z},   // R9 write load @9
    '{1'b0,1'b0,1'b1,1'b1,4'h0,1'b1,1'b0,6'd0,Z,  1'b0,Z},   // R9 ->8
    '{1'b0,1'b0,1'b1,1'b1,4'h0,1'b1,1'b0,6'd0,E9, 1'b0,Z},   // R9 ->11
    '{1'b0,1'b0,1'b1,1'b1,4'h0,1'b1,1'b0,6'd0,E8, 1'b0,Z},   // R9 ->10
    '{1'b1,1'b0,1'b0,1'b1,4'h0,1'b1,1'b0,6'd0,GB, 1'b0,Z},   // R2 stall, junk on din
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,6'd0,E11,1'b0,Z},
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,6'd0,E10,1'b0,Z},
    '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,6'd9,Z,  1'b1,E9},  // R9 read 9
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,6'd0,Z,  1'b1,E8},  // R9
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,6'd0,Z,  1'b1,E11}, // R9
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,6'd0,Z,  1'b1,E10}, // R9
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,6'd0,Z,  1'b1,E9},  // R9 wrap
    '{1'b0,1'b0,1'b0,1'b0,4'hA,1'b0,1'b0,6'd6,Z,  1'b0,Z},   // R6 R11 masked write right after read
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b0,Z},
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,NW, 1'b0,Z},
    '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'd6,Z,  1'b1,merge(DA, NW, 4'hA)}, // R6
    '{1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b0,Z},   // R3
    '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'd0,Z,  1'b0,Z}    // R7 advance after deselect
  };

  task automatic idle();
    cke_n = 0; cs_n = 1; adv = 0; we_n = 1; bw_n = 4'hF; order = 0; addr = '0; din = '0;
  endtask

  task automatic cmd(bit c_adv, bit c_we_n, logic [3:0] c_bw, logic [AW-1:0] c_a, logic [DW-1:0] c_d);
    cke_n = 0; cs_n = 0; adv = c_adv; we_n = c_we_n; bw_n = c_bw; addr = c_a; din = c_d;
  endtask

  task automatic fwd_test(logic [3:0] b, logic [DW-1:0] newd, logic [DW-1:0] exp);
    @(negedge clk); cmd(0, 0, b, 6'd20, '0);
    @(negedge clk); cmd(0, 1, 4'hF, 6'd20, '0);
    @(negedge clk); idle(); din = newd; #1;
    chk("R11 forward", dout, exp);
    @(negedge clk); idle(); cmd(0, 1, 4'hF, 6'd20, '0);
    @(posedge clk); #1;
    chk("R11 stored", dout, exp);
  endtask

  localparam logic [DW-1:0] F20 = 36'h5A5A5A5A5, G20 = 36'hC3C3C3C3C;

  initial begin
    idle(); oe_n = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", dout_oe, 0);
    @(negedge clk); rst_n = 1;
    #1 chk("R1 after reset", dout_oe, 0);
    @(negedge clk); cmd(1, 1, 4'hF, 6'd3, '0);
    @(posedge clk); #1 chk("R1 advance after reset", dout_oe, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cke_n = V[i].cke_n; cs_n = V[i].cs_n; adv = V[i].adv; we_n = V[i].we_n;
      bw_n = V[i].bw_n; order = V[i].ord; oe_n = V[i].oe_n; addr = V[i].a; din = V[i].d;
      @(posedge clk); #1;
      checks++;
      if (dout_oe !== V[i].eo || (V[i].eo && dout !== V[i].ed)) begin
        fails++;
        $display("FAIL row %0d (see row tag) actual=%b/%h expected=%b/%h",
                 i, dout_oe, dout, V[i].eo, V[i].ed);
      end
    end

    oe_n = 0;
    fwd_test(4'h0, F20, F20);                      // R11 full word
    fwd_test(4'b1001, G20, merge(F20, G20, 4'b1001)); // R11 R6 partial

    @(negedge clk); idle(); cmd(0, 1, 4'hF, 6'd20, '0);
    @(negedge clk); idle(); rst_n = 0; #1;
    chk("R1 reset mid-read", dout_oe, 0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule